// File: doc/BRIEF.md
# AXI Address Field Legality Checker

This block watches one AXI address channel, either write address or read address, and judges the request fields at every accepted handshake. It looks at the start address, the beat count field, the transfer size field and the burst type field. From them it works out the shape of the burst: the total byte span, where the burst ends, and whether a wrapping burst is aligned and of a legal length. Each broken rule sets its own sticky flag. A separate code records which rule failed first.

The checker only observes the channel and never drives it. It sits beside a manager or a subordinate, in simulation or in silicon. The width of the data bus is a parameter, and that width limits the legal transfer size. The flags and the first-error code stay set until reset, so a single illegal request seen at any time is still visible at the end of a run.

Top module: `axi_addr_legality_chk`

## Requirements
- R1: A handshake whose burst type field is 2'b11 (reserved) sets `rule_flags[0]`; rule code 1.
- R2: A handshake whose transfer size 2^size bytes is larger than the data bus width in bytes sets `rule_flags[1]`; rule code 2.
- R3: A wrapping burst (burst type 2'b10) whose start address is not a multiple of 2^size sets `rule_flags[2]`; rule code 3.
- R4: A wrapping burst whose beat count (length field + 1) is not 2, 4, 8 or 16 sets `rule_flags[3]`; rule code 4.
- R5: An incrementing burst (burst type 2'b01) sets `rule_flags[4]` (rule code 5) when bits 12 and up of its end address differ from those of its start address. The end address is start + ((length+1) << size) - 1, and a carry past the top address bit counts as a crossing.
- R6: A fixed burst (burst type 2'b00) never triggers R3, R4 or R5. An incrementing burst never triggers R3 or R4.
- R7: Fields are judged only in a cycle where valid and ready are both high. In any other cycle neither the flags nor the code change, whatever the fields hold.
- R8: Synchronous active-low reset clears all flags and sets `first_code` to 0. The flags are sticky and never fall without reset.
- R9: `first_code` takes the code of the first handshake that breaks any rule. When that handshake breaks several rules, the lowest code is taken. The value is then held until reset.
- R10: Flags and code are registered: a handshake at a rising clock edge is reflected in the outputs right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ax_valid | input | 1 | Address channel valid |
| ax_ready | input | 1 | Address channel ready |
| ax_addr | input | ADDR_W | Start address |
| ax_len | input | LEN_W | Beat count minus one |
| ax_size | input | 3 | Log2 of bytes per beat |
| ax_burst | input | 2 | Burst type: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| rule_flags | output | 5 | Sticky per-rule flags, bit k-1 for rule code k |
| first_code | output | 3 | Code of the first failure, 0 while none |

## Verification
The bench uses a 32-bit address, an 8-bit length field and a 4-byte data bus. With the narrow bus, sizes 3 to 7 become oversized, so R2 can be reached and can overlap with the wrap rules. With the 8-bit length field, bursts can span up to 32 KB and can cross a 4 KB boundary from many start offsets, including a carry past the top of the address space. Directed cases hit the exact boundary edges, and a randomized stretch with periodic resets is checked against a behavioural model on every clock.

// File: rtl/axi_chk_pkg.sv
// Package: shared rule codes, burst encodings and the violation vector type
// for the address legality checker. Assumes five rules, numbered from 1.
package axi_chk_pkg;

    localparam int NUM_RULES = 5;

    // Burst type field encodings
    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] BURST_WRAP  = 2'b10;
    localparam logic [1:0] BURST_RSVD  = 2'b11;

    // Rule codes; lower value has higher priority
    typedef enum logic [2:0] {
        CODE_NONE          = 3'd0,
        CODE_RSVD_BURST    = 3'd1,
        CODE_OVERSIZE      = 3'd2,
        CODE_WRAP_MISALIGN = 3'd3,
        CODE_WRAP_LEN      = 3'd4,
        CODE_CROSS_4K      = 3'd5
    } rule_code_e;

    // Bit k-1 holds the violation of rule code k
    typedef logic [NUM_RULES-1:0] rule_vec_t;

endpackage

// File: rtl/axc_field_decode.sv
// Module: axc_field_decode
// Purely combinational decode of the encoding rules. It flags a reserved
// burst type and a transfer size wider than the data bus.
// Assumes DATA_BYTES is a power of two between 1 and 128.
module axc_field_decode #(
    parameter int DATA_BYTES = 8
) (
    input  logic [2:0] size,
    input  logic [1:0] burst,
    output logic       bad_burst,
    output logic       bad_size
);
    import axi_chk_pkg::*;

    localparam int          SIZE_MAX_I = $clog2(DATA_BYTES);
    localparam logic [2:0]  SIZE_MAX   = 3'(SIZE_MAX_I);

    // Compare both fields against their legal range
    always_comb begin
        bad_burst = (burst == BURST_RSVD);
        bad_size  = (size > SIZE_MAX);
    end

endmodule

// File: rtl/axc_burst_shape.sv
// Module: axc_burst_shape
// Combinational burst-shape arithmetic. It checks wrap start alignment and
// wrap beat count, and it computes the byte span and end address of
// incrementing bursts to find 4 KB boundary crossings.
// Assumes ADDR_W > 12 and ADDR_W + 1 >= LEN_W + 8.
module axc_burst_shape #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        size,
    input  logic [1:0]        burst,
    output logic              wrap_misalign,
    output logic              wrap_badlen,
    output logic              cross_4k
);
    import axi_chk_pkg::*;

    localparam int SPAN_W = LEN_W + 8;
    localparam int END_W  = ADDR_W + 1;
    localparam int PAGE_B = 12;

    logic [SPAN_W-1:0] beats;
    logic [SPAN_W-1:0] span;
    logic [END_W-1:0]  end_addr;
    logic [ADDR_W-1:0] size_mask;
    logic              is_wrap;
    logic              is_incr;
    logic              len_ok;

    // Span of the burst in bytes and its last byte address
    always_comb begin
        beats    = SPAN_W'(len) + SPAN_W'(1);
        span     = beats << size;
        end_addr = {1'b0, addr} + END_W'(span) - END_W'(1);
    end

    // Low address bits that must be zero for an aligned wrap start
    always_comb begin
        size_mask = (ADDR_W'(1) << size) - ADDR_W'(1);
    end

    // Legal wrap beat counts are 2, 4, 8 and 16
    always_comb begin
        len_ok = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                 (len == LEN_W'(7)) || (len == LEN_W'(15));
    end

    // Combine burst type with the shape tests
    always_comb begin
        is_wrap       = (burst == BURST_WRAP);
        is_incr       = (burst == BURST_INCR);
        wrap_misalign = is_wrap && (|(addr & size_mask));
        wrap_badlen   = is_wrap && !len_ok;
        cross_4k      = is_incr &&
                        (end_addr[END_W-1:PAGE_B] != {1'b0, addr[ADDR_W-1:PAGE_B]});
    end

endmodule

// File: rtl/axc_violation_log.sv
// Module: axc_violation_log
// Keeps one sticky flag per rule and records the code of the first failing
// handshake, taking the lowest failing rule of that handshake.
// Assumes viol is only meaningful when hs is high.
module axc_violation_log (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hs,
    input  axi_chk_pkg::rule_vec_t viol,
    output axi_chk_pkg::rule_vec_t flags,
    output logic [2:0]             code
);
    import axi_chk_pkg::*;

    rule_code_e low_code;
    rule_code_e code_q;

    // Lowest set violation wins the priority
    always_comb begin
        low_code = CODE_NONE;
        for (int i = NUM_RULES - 1; i >= 0; i--) begin
            if (viol[i]) low_code = rule_code_e'(3'(i + 1));
        end
    end

    // One sticky flag per rule
    for (genvar g = 0; g < NUM_RULES; g++) begin : g_sticky
        // Set on a failing handshake, clear only in reset
        always_ff @(posedge clk) begin
            if (!rst_n)               flags[g] <= 1'b0;
            else if (hs && viol[g])   flags[g] <= 1'b1;
        end
    end

    // Capture the first failure code once
    always_ff @(posedge clk) begin
        if (!rst_n)                                  code_q <= CODE_NONE;
        else if (hs && (code_q == CODE_NONE) && |viol) code_q <= low_code;
    end

    assign code = code_q;

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & $past(flags)) == $past(flags)));                     // R8
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 3'd0) |=> (code == $past(code)));                     // R9
    AST_CODE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (code != 3'd0) |-> flags[code - 3'd1]);                        // R9
    AST_QUIET_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !hs |=> ($stable(flags) && $stable(code)));                    // R7

endmodule

// File: rtl/axi_addr_legality_chk.sv
// Module: axi_addr_legality_chk
// Top of the address-channel legality checker. It samples the address
// fields at each valid/ready handshake and keeps sticky per-rule flags plus
// a first-error code. Observes only; drives nothing back onto the channel.
// Assumes ADDR_W > 12 and DATA_BYTES a power of two up to 128.
module axi_addr_legality_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8,
    parameter int DATA_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ax_valid,
    input  logic              ax_ready,
    input  logic [ADDR_W-1:0] ax_addr,
    input  logic [LEN_W-1:0]  ax_len,
    input  logic [2:0]        ax_size,
    input  logic [1:0]        ax_burst,
    output logic [4:0]        rule_flags,
    output logic [2:0]        first_code
);
    import axi_chk_pkg::*;

    logic      hs;
    logic      bad_burst, bad_size;
    logic      wrap_misalign, wrap_badlen, cross_4k;
    rule_vec_t viol;
    rule_vec_t flags;

    // Accepted transfer on the address channel
    always_comb hs = ax_valid && ax_ready;

    axc_field_decode #(
        .DATA_BYTES(DATA_BYTES)
    ) u_decode (
        .size      (ax_size),
        .burst     (ax_burst),
        .bad_burst (bad_burst),
        .bad_size  (bad_size)
    );

    axc_burst_shape #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_shape (
        .addr          (ax_addr),
        .len           (ax_len),
        .size          (ax_size),
        .burst         (ax_burst),
        .wrap_misalign (wrap_misalign),
        .wrap_badlen   (wrap_badlen),
        .cross_4k      (cross_4k)
    );

    // Pack the rule results in code order
    always_comb viol = {cross_4k, wrap_badlen, wrap_misalign, bad_size, bad_burst};

    axc_violation_log u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .hs    (hs),
        .viol  (viol),
        .flags (flags),
        .code  (first_code)
    );

    assign rule_flags = flags;

    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && ax_burst == 2'b11) |=> rule_flags[0]);                  // R1
    AST_WRAP3_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && ax_burst == 2'b10 && ax_len == LEN_W'(2)) |=> rule_flags[3]); // R4
    AST_PAGE_END_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && ax_burst == 2'b01 && ax_addr[11:0] == 12'hFFF && ax_len != '0)
        |=> rule_flags[4]);                                            // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (rule_flags == 5'd0 && first_code == 3'd0));        // R8

endmodule

// File: tb/sim_axi_addr_legality_chk.sv
module sim_axi_addr_legality_chk;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;
    localparam int DBYTES = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ax_valid = 1'b0;
    logic              ax_ready = 1'b0;
    logic [ADDR_W-1:0] ax_addr = '0;
    logic [LEN_W-1:0]  ax_len = '0;
    logic [2:0]        ax_size = '0;
    logic [1:0]        ax_burst = '0;
    logic [4:0]        rule_flags;
    logic [2:0]        first_code;

    int         n_tests = 0;
    int         n_fail  = 0;
    logic [4:0] exp_flags = '0;
    int         exp_code  = 0;

    always #10 clk = ~clk;   // 50 MHz

    axi_addr_legality_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DBYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .ax_valid(ax_valid), .ax_ready(ax_ready),
        .ax_addr(ax_addr), .ax_len(ax_len), .ax_size(ax_size), .ax_burst(ax_burst),
        .rule_flags(rule_flags), .first_code(first_code));

    task automatic check(input string tag);
        n_tests++;
        if (rule_flags !== exp_flags) begin
            n_fail++;
            $display("FAIL %s flags: actual %b expected %b", tag, rule_flags, exp_flags);
        end
        n_tests++;
        if (int'(first_code) != exp_code) begin
            n_fail++;
            $display("FAIL %s code: actual %0d expected %0d", tag, first_code, exp_code);
        end
    endtask

    // Behavioural model of one cycle, then check after the edge (R10)
    task automatic step(input logic v, input logic r, input logic [31:0] a,
                        input int l, input int s, input int b, input string tag);
        logic [4:0] bad;
        longint     st, en;
        ax_valid = v; ax_ready = r; ax_addr = a;
        ax_len = LEN_W'(l); ax_size = 3'(s); ax_burst = 2'(b);
        bad = '0;
        if (v && r) begin
            st = longint'(a);
            en = st + (longint'(l + 1) << s) - 1;
            bad[0] = (b == 3);
            bad[1] = ((1 << s) > DBYTES);
            bad[2] = (b == 2) && ((st % (longint'(1) << s)) != 0);
            bad[3] = (b == 2) && !((l + 1) inside {2, 4, 8, 16});
            bad[4] = (b == 1) && ((en >> 12) != (st >> 12));
            exp_flags = exp_flags | bad;
            if (exp_code == 0) begin
                for (int i = 4; i >= 0; i--) if (bad[i]) exp_code = i + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0; ax_valid = 1'b0; ax_ready = 1'b0;
        exp_flags = '0; exp_code = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(tag);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset("R8 reset state");
        // R7: illegal fields without a full handshake
        step(1, 0, 32'h0000_0003, 2, 7, 3, "R7 valid only");
        step(0, 1, 32'h0000_0FFF, 9, 7, 2, "R7 ready only");
        // Legal requests
        step(1, 1, 32'h0000_1000, 15, 2, 1, "R5 legal incr");
        step(1, 1, 32'h0000_0FF0, 3, 2, 1, "R5 ends on page edge");
        step(1, 1, 32'h0000_0040, 3, 2, 2, "R4 wrap len 4");
        step(1, 1, 32'h0000_0080, 15, 2, 2, "R4 wrap len 16");
        step(1, 1, 32'h0000_0082, 1, 1, 2, "R3 wrap aligned size 1");
        step(1, 1, 32'h0000_0FFF, 40, 2, 0, "R6 fixed no shape rules");
        step(1, 1, 32'h0000_0003, 2, 2, 1, "R6 incr no wrap rules");
        // R1 then R2: code stays at first
        step(1, 1, 32'h0000_0000, 0, 0, 3, "R1 reserved burst");
        step(1, 1, 32'h0000_0000, 0, 3, 1, "R2 oversize, R9 code held");
        step(0, 0, 32'h0, 0, 0, 0, "R8 sticky idle");
        do_reset("R8 clear after errors");
        // Several rules at once: lowest code wins
        step(1, 1, 32'h0000_0004, 2, 4, 2, "R9 R2 R3 R4 together");
        do_reset("R8 reset");
        step(1, 1, 32'h0000_0042, 3, 2, 2, "R3 wrap misaligned");
        step(1, 1, 32'h0000_0040, 31, 0, 2, "R4 wrap len 32");
        do_reset("R8 reset");
        step(1, 1, 32'h0000_0FF4, 3, 2, 1, "R5 crossing");
        do_reset("R8 reset");
        step(1, 1, 32'hFFFF_FFF0, 31, 0, 1, "R5 top carry");
        step(1, 1, 32'h0000_0000, 255, 7, 1, "R5 R2 large span");
        do_reset("R8 reset");
        step(1, 1, 32'h0000_0040, 0, 2, 2, "R4 wrap len 1");
        // Randomized traffic against the model
        for (int k = 0; k < 600; k++) begin
            logic [31:0] a;
            int l, s, b;
            if (k % 20 == 19) do_reset("R8 random reset");
            a = $urandom;
            if ($urandom % 2 == 0) a[11:8] = 4'hF;
            l = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 17);
            s = ($urandom % 3 == 0) ? int'($urandom % 8) : int'($urandom % 3);
            if ($urandom % 2 == 0) a = a & ~((32'd1 << s) - 32'd1);
            b = int'($urandom % 4);
            step(1'($urandom), 1'($urandom), a, l, s, b, "R10 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule